// File: doc/BRIEF.md
# Clock-Stop SPI Master Shifter

This block is a synchronous SPI master. Its serial clock idles high and toggles only while a word is being moved. A host presents a clock divider setting, a word length code and a transmit word, then pulses `start`. The block lowers an active-low select and places the most significant transmit bit on the data output. It then runs the serial clock through one low/high cycle per bit. Output data changes on falling serial-clock edges and input data is captured on rising ones. A closing interval follows the last bit, after which select is released and the received word is presented with a one-cycle `done` pulse.

Every serial-clock interval is a whole number of system cycles and derives from the divider value. Odd divider settings give a symmetric clock. Even settings give a high phase one cycle longer than the low phase. The data output has its own enable, so the pad can release the line one high-interval after the final rising edge. Select stays low for one full serial period after that edge.

Top module: `cstp_spi_master`

## Requirements
- R1: After reset and whenever no transfer is running, `ss_n` = 1, `sclk` = 1, `mosi_oe` = 0, `busy` = 0 and `done` = 0.
- R2: With effective divider d, the serial period is d+1 system cycles. The high interval is H = floor(d/2)+1 cycles and the low interval is L = ceil(d/2) cycles.
- R3: A divider value of 0 behaves exactly like a divider value of 1.
- R4: In the first cycle after `start` is accepted, `ss_n` goes to 0 and `mosi_oe` goes to 1, with transmit bit n-1 on `mosi`. `sclk` stays high for H cycles and then falls for the first time.
- R5: Bits leave MSB first, from bit n-1 down to bit 0 of `tx_word`. `mosi` changes only together with a falling `sclk` edge, never at the first falling edge, and stays constant while `sclk` is high.
- R6: `miso` is captured on each rising `sclk` edge. The n captured bits form `rx_word[n-1:0]`, with the first captured bit in position n-1 and upper bits zero.
- R7: After the last rising edge, `mosi_oe` stays 1 for H cycles and then drops to 0. `ss_n` stays 0 for d+1 cycles after that edge and `sclk` stays high throughout.
- R8: `busy` is 1 from the cycle after acceptance until `ss_n` returns high. In that first released cycle `done` is 1 for exactly one cycle with the new `rx_word`, and `rx_word` changes only when `done` is 1.
- R9: A `start` pulse that arrives while `busy` is 1 has no effect on the running transfer.
- R10: `len_code` value k (0 to 31) selects a word of k+1 bits. `div_val`, `len_code` and `tx_word` are captured only when `start` is accepted, and later changes do not alter a running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| div_val | input | DIV_W | Serial clock divider setting |
| len_code | input | LEN_W | Word length minus one |
| tx_word | input | MAX_W | Transmit word, right-justified |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for `mosi` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | MAX_W | Received word, right-justified |

## Verification
The assertions take `start` to be the only input whose timing matters. `div_val`, `len_code` and `tx_word` may change freely, because the block reads them only at acceptance. Capturing on rising edges also relies on `miso` changing only while `sclk` is low or as select falls. The bench's slave model keeps to this by updating `miso` half a system cycle after each observed falling edge, except the first. The bench also scrambles the configuration inputs and re-pulses `start` mid-word, so any dependence on them after capture would show in the cycle-by-cycle comparison.

// File: rtl/cstp_pkg.sv
package cstp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TAIL
    } phase_t;

    typedef struct packed {
        logic load;
        logic rise;
        logic shift;
        logic finish;
    } shift_ev_t;

    // Divider settings below one cannot be produced from the system clock.
    function automatic int unsigned eff_div(int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

    function automatic int unsigned hi_cycles(int unsigned d);
        return (d / 2) + 1;
    endfunction

    function automatic int unsigned lo_cycles(int unsigned d);
        return d - (d / 2);
    endfunction

endpackage

// File: rtl/cstp_phase_seq.sv
module cstp_phase_seq
    import cstp_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div_val,
    input  logic [LEN_W-1:0] len_code,
    output phase_t           phase,
    output shift_ev_t        ev
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] hi_lim;
    logic [DIV_W-1:0] lo_lim;
    logic [LEN_W:0]   bits_left;
    int unsigned      d_eff;
    logic             cnt_zero;

    always_comb begin
        d_eff    = eff_div(32'(div_val));
        cnt_zero = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            hi_lim    <= DIV_W'(1);
            lo_lim    <= DIV_W'(1);
            bits_left <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_LEAD;
                        hi_lim    <= DIV_W'(hi_cycles(d_eff));
                        lo_lim    <= DIV_W'(lo_cycles(d_eff));
                        cnt       <= DIV_W'(hi_cycles(d_eff) - 1);
                        bits_left <= (LEN_W+1)'(len_code) + 1'b1;
                    end
                end
                PH_LEAD: begin
                    if (cnt_zero) begin
                        phase <= PH_LOW;
                        cnt   <= lo_lim - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_zero) begin
                        phase     <= PH_HIGH;
                        cnt       <= hi_lim - 1'b1;
                        bits_left <= bits_left - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt_zero) begin
                        phase <= (bits_left == '0) ? PH_TAIL : PH_LOW;
                        cnt   <= lo_lim - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (cnt_zero) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ev.load   = (phase == PH_IDLE) && start;
        ev.rise   = (phase == PH_LOW) && cnt_zero;
        ev.shift  = (phase == PH_HIGH) && cnt_zero && (bits_left != '0);
        ev.finish = (phase == PH_TAIL) && cnt_zero;
    end

    // Checker-side run counters for the clock interval widths.
    logic [DIV_W-1:0] low_run;
    logic [DIV_W-1:0] high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            low_run  <= (phase == PH_LOW) ? low_run + 1'b1 : '0;
            high_run <= (phase == PH_HIGH) ? high_run + 1'b1 : '0;
        end
    end

    // R2
    lo_width_chk: assert property (@(posedge clk) disable iff (rst)
        ev.rise |-> (low_run == lo_lim - 1'b1));

    // R2
    hi_width_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_HIGH) && cnt_zero) |-> (high_run == hi_lim - 1'b1));

    // R3
    nonzero_lim_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> ((lo_lim != '0) && (hi_lim != '0)));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase != PH_IDLE) && start) |=> ($stable(hi_lim) && $stable(lo_lim)));

endmodule

// File: rtl/cstp_shifter.sv
module cstp_shifter
    import cstp_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  shift_ev_t        ev,
    input  logic [MAX_W-1:0] tx_word,
    input  logic [LEN_W-1:0] len_code,
    input  logic             miso,
    output logic             mosi,
    output logic [MAX_W-1:0] rx_word,
    output logic             done
);

    logic [MAX_W-1:0] tx_sh;
    logic [MAX_W-1:0] rx_sh;
    logic [LEN_W:0]   align;

    always_comb begin
        align = (LEN_W+1)'(MAX_W - 1) - (LEN_W+1)'(len_code);
        mosi  = tx_sh[MAX_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
            done    <= 1'b0;
        end else begin
            done <= ev.finish;
            if (ev.load) begin
                tx_sh <= tx_word << align;
                rx_sh <= '0;
            end else begin
                if (ev.shift) begin
                    tx_sh <= {tx_sh[MAX_W-2:0], 1'b0};
                end
                if (ev.rise) begin
                    rx_sh <= {rx_sh[MAX_W-2:0], miso};
                end
            end
            if (ev.finish) begin
                rx_word <= rx_sh;
            end
        end
    end

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/cstp_spi_master.sv
module cstp_spi_master
    import cstp_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int DIV_W = 8,
    localparam int LEN_W = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div_val,
    input  logic [LEN_W-1:0] len_code,
    input  logic [MAX_W-1:0] tx_word,
    input  logic             miso,
    output logic             ss_n,
    output logic             sclk,
    output logic             mosi,
    output logic             mosi_oe,
    output logic             busy,
    output logic             done,
    output logic [MAX_W-1:0] rx_word
);

    phase_t    phase;
    shift_ev_t ev;

    cstp_phase_seq #(
        .DIV_W (DIV_W),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .div_val  (div_val),
        .len_code (len_code),
        .phase    (phase),
        .ev       (ev)
    );

    cstp_shifter #(
        .MAX_W (MAX_W),
        .LEN_W (LEN_W)
    ) u_shf (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .tx_word  (tx_word),
        .len_code (len_code),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word),
        .done     (done)
    );

    always_comb begin
        ss_n    = (phase == PH_IDLE);
        busy    = (phase != PH_IDLE);
        sclk    = (phase != PH_LOW);
        mosi_oe = (phase == PH_LEAD) || (phase == PH_LOW) || (phase == PH_HIGH);
    end

    // R4
    sclk_under_select_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> (!ss_n && mosi_oe));

    // R5
    mosi_high_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mosi_oe && sclk && $past(mosi_oe) && $past(sclk)) |-> $stable(mosi));

    // R7
    tail_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mosi_oe) |-> (sclk && !ss_n));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> (sclk && !mosi_oe && !busy));

endmodule

// File: tb/cstp_spi_master_tb.sv
`timescale 1ns/1ps
module cstp_spi_master_tb;

    localparam int MAX_W = 32;
    localparam int DIV_W = 8;
    localparam int LEN_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic [LEN_W-1:0] len_code = '0;
    logic [MAX_W-1:0] tx_word = '0;
    logic             miso = 1'b0;
    logic             ss_n, sclk, mosi, mosi_oe, busy, done;
    logic [MAX_W-1:0] rx_word;

    always #2.5 clk = ~clk;

    cstp_spi_master #(.MAX_W(MAX_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .div_val(div_val),
        .len_code(len_code), .tx_word(tx_word), .miso(miso),
        .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe),
        .busy(busy), .done(done), .rx_word(rx_word)
    );

    typedef struct {
        bit ss_n;
        bit sclk;
        bit oe;
        bit mosi;
        bit busy;
        bit done;
        bit chk_rx;
        logic [31:0] rx;
    } exp_t;

    exp_t eq[$];
    int total = 0;
    int bad = 0;
    bit running = 0;

    // slave model state
    logic [31:0] s_word = '0;
    int s_n = 1;
    int s_idx = 0;
    bit prev_ss = 1, prev_sclk = 1, got_rise = 0;

    task automatic report(string req, string what, logic [31:0] act, logic [31:0] expv);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
    endtask

    function automatic exp_t mk(bit s, bit c, bit o, bit m, bit b, bit d);
        exp_t e;
        e.ss_n = s; e.sclk = c; e.oe = o; e.mosi = m; e.busy = b; e.done = d;
        e.chk_rx = 0; e.rx = '0;
        return e;
    endfunction

    // Reference timeline per R2..R8, R10, built from the requirements.
    task automatic build_exp(int dv, int lc, logic [31:0] w, logic [31:0] sw);
        int d, h, l, n;
        logic [63:0] mask;
        exp_t e;
        d = (dv < 1) ? 1 : dv;           // R3
        h = d / 2 + 1;
        l = d - d / 2;
        n = lc + 1;                       // R10
        mask = (64'd1 << n) - 64'd1;
        for (int i = 0; i < h; i++) eq.push_back(mk(0, 1, 1, w[n-1], 1, 0));
        for (int k = n - 1; k >= 0; k--) begin
            for (int i = 0; i < l; i++) eq.push_back(mk(0, 0, 1, w[k], 1, 0));
            for (int i = 0; i < h; i++) eq.push_back(mk(0, 1, 1, w[k], 1, 0));
        end
        for (int i = 0; i < l; i++) eq.push_back(mk(0, 1, 0, 0, 1, 0));
        e = mk(1, 1, 0, 0, 0, 1);
        e.chk_rx = 1;
        e.rx = sw & mask[31:0];          // R6
        eq.push_back(e);
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (running && !rst) begin
            exp_t e;
            if (eq.size() > 0) e = eq.pop_front();
            else e = mk(1, 1, 0, 0, 0, 0);   // R1 idle
            total++;
            if (ss_n !== e.ss_n) report("R4/R7", "ss_n", 32'(ss_n), 32'(e.ss_n));
            if (sclk !== e.sclk) report("R2", "sclk", 32'(sclk), 32'(e.sclk));
            if (mosi_oe !== e.oe) report("R7", "mosi_oe", 32'(mosi_oe), 32'(e.oe));
            if (e.oe && (mosi !== e.mosi)) report("R5", "mosi", 32'(mosi), 32'(e.mosi));
            if (busy !== e.busy) report("R8", "busy", 32'(busy), 32'(e.busy));
            if (done !== e.done) report("R8", "done", 32'(done), 32'(e.done));
            if (e.chk_rx) begin
                total++;
                if (rx_word !== e.rx) report("R6", "rx_word", rx_word, e.rx);
            end
        end
    end

    // slave: presents MSB at select, next bit after each fall that follows a rise
    always @(negedge clk) begin
        if (!ss_n && prev_ss) begin
            s_idx = s_n - 1;
            miso = s_word[s_idx];
            got_rise = 0;
        end else if (!ss_n) begin
            if (sclk && !prev_sclk) got_rise = 1;
            if (!sclk && prev_sclk && got_rise && s_idx > 0) begin
                s_idx--;
                miso = s_word[s_idx];
            end
        end
        prev_ss = ss_n;
        prev_sclk = sclk;
    end

    task automatic xfer(int dv, int lc, logic [31:0] w, logic [31:0] sw, bit mess);
        @(negedge clk);
        div_val = DIV_W'(dv);
        len_code = LEN_W'(lc);
        tx_word = w;
        s_word = sw;
        s_n = lc + 1;
        start = 1'b1;
        @(posedge clk);
        #1;
        build_exp(dv, lc, w, sw);
        start = 1'b0;
        if (mess) begin
            // R9, R10: new settings and a second start must not disturb the word
            div_val = DIV_W'(dv + 3);
            len_code = LEN_W'(lc ^ 5'h0A);
            tx_word = ~w;
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (eq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        total++;
        if (ss_n !== 1'b1 || sclk !== 1'b1 || mosi_oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0)
            report("R1", "idle outputs", {27'd0, ss_n, sclk, mosi_oe, busy, done}, 32'h18);
        running = 1;
        xfer(0, 0, 32'h1, 32'h1, 0);                 // R3 divider 0, single bit
        xfer(1, 7, 32'hA5, 32'h3C, 0);               // R2 symmetric fastest
        xfer(2, 7, 32'h5A, 32'hC3, 0);               // R2 even divider
        xfer(3, 15, 32'hBEEF, 32'h1234, 0);          // R5 R6
        xfer(4, 31, 32'hDEADBEEF, 32'h8BADF00D, 1);  // R9 R10
        xfer(7, 4, 32'h15, 32'h0A, 0);               // R2 odd wide
        xfer(0, 31, 32'h80000001, 32'h7FFFFFFE, 1);  // R3 R9
        xfer(6, 12, 32'h1FFF, 32'h0AAA, 0);          // R7 tail with even divider
        xfer(5, 2, 32'h6, 32'h5, 1);                 // R10 short word
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule